// File: doc/BRIEF.md
# Region-of-Interest Timing and Address Generator

This block times and addresses a rectangular window of pixels for one port of an image memory. Several such ports share a two-wire timing bus. One wire carries a horizontal sync and the other a vertical sync. The port set to the transmitter role makes the bus timing from its programmed window size plus programmable blanking counts. Ports in the receiver role follow that timing. In either role the block produces a pixel-enable strobe and a memory address for every pixel of its window. The address is the start address, plus the line index times the line pitch, plus the pixel index. It is formed by adding and incrementing, with no multiplier.

A receiver can shift its window by a programmed number of pixels and lines against the incoming line and frame. A destination port can therefore capture a stream that has passed through processing stages with a known latency. For example, after a stage that delays the data by 12 pixels and 8 lines, the destination is set to capture 12 pixels and 8 lines later. A start command arms one frame. A done flag reports that the last pixel of the window has been addressed. All configuration arrives through a simple register write port.

Top module: `roi_timing_gen`

## Requirements
- R1: After reset, pix_en, done, tbus_out and tbus_oe are all 0, and the block is in the receiver role.
- R2: A write with cfg_we high stores cfg_data by cfg_sel: 0 start address, 1 line pitch, 2 window width, 3 window height, 4 horizontal blanking, 5 vertical blanking, 6 horizontal offset, 7 vertical offset, 8 control. In the control word, bit 0 is start, bit 1 selects the transmitter role and bit 2 is repeat. Role changes only on a write with start set.
- R3: In the transmitter role, from the cycle after a start write, each line lasts width+hblank cycles and each frame lasts height+vblank lines. tbus_out[0] (H sync) is high for the last cycle of each line. tbus_out[1] (V sync) is high together with H sync on the last line of the frame.
- R4: With line position h and line index v counted from the start of the frame, pix_en is high exactly when hoff <= h < hoff+width and voff <= v < voff+height.
- R5: While pix_en is high, addr equals start + y*pitch + x, where x = h-hoff and y = v-voff.
- R6: A start write clears done. done goes high in the cycle after the last window pixel has been enabled, and it stays high until the next start write.
- R7: A transmitter without repeat stops after one frame, leaving the bus and pix_en low. With repeat set, frames follow back to back. A control write that clears repeat makes the transmitter stop at the end of the current frame.
- R8: A receiver armed by a start write ignores H syncs until a V sync arrives. From the next cycle its line position restarts at 0 after every H sync, and its line index counts H syncs.
- R9: A receiver places its window at its own offsets inside the followed frame. After its last pixel it raises no further pix_en until it is armed again.
- R10: tbus_oe is high exactly in the transmitter role. In the receiver role tbus_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_data | input | AW | Register write data |
| tbus_in | input | 2 | Timing bus as seen by a receiver: bit 0 H sync, bit 1 V sync |
| tbus_out | output | 2 | Timing bus driven by a transmitter: bit 0 H sync, bit 1 V sync |
| tbus_oe | output | 1 | High when this port drives the timing bus |
| pix_en | output | 1 | Window pixel strobe |
| addr | output | AW | Memory address of the current pixel |
| done | output | 1 | Last window pixel has been addressed |

## Verification
The bench builds the block with an 8-bit counter width and a 16-bit address. This keeps every frame down to a few dozen cycles. The transmitter is swept over all widths from 1 to 4, heights from 1 to 3, horizontal blanking from 0 to 2, vertical blanking from 0 to 1, and every offset that fits inside the blanking. Each cycle's strobe, address, syncs and done flag are compared with values computed from the line and frame arithmetic. This reaches the zero-blanking cases, where the syncs land on a window pixel and consecutive lines abut. A second instance in the receiver role then follows a repeating transmitter with offsets of 2 pixels and 1 line. The bench checks that the receiver ignores the first frame, is aligned to the second, falls silent afterwards, and that the transmitter stops once repeat is cleared.

// File: rtl/roi_timing_gen.sv
module roi_timing_gen #(
  parameter int CW = 12,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic [1:0]    tbus_in,
  output logic [1:0]    tbus_out,
  output logic          tbus_oe,
  output logic          pix_en,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam int KW = CW + 1;

  logic [AW-1:0] r_start, r_pitch, line_base;
  logic [CW-1:0] r_w, r_h, r_hb, r_vb, r_ho, r_vo, px;
  logic [KW-1:0] hcnt, vcnt;
  logic          role_tx, rpt, wait_v, run;

  logic [KW-1:0] w_k, h_k, ho_k, vo_k, hlast, vlast;
  assign w_k   = KW'(r_w);
  assign h_k   = KW'(r_h);
  assign ho_k  = KW'(r_ho);
  assign vo_k  = KW'(r_vo);
  assign hlast = w_k + KW'(r_hb) - KW'(1);
  assign vlast = h_k + KW'(r_vb) - KW'(1);

  logic ctl_wr, go, line_end, last_line, in_h, in_v, last_pix;
  assign ctl_wr    = cfg_we && cfg_sel == 4'd8;
  assign go        = ctl_wr && cfg_data[0];
  assign line_end  = hcnt == hlast;
  assign last_line = vcnt == vlast;
  assign in_h      = hcnt >= ho_k && hcnt < ho_k + w_k;
  assign in_v      = vcnt >= vo_k && vcnt < vo_k + h_k;
  assign pix_en    = run && in_h && in_v;
  assign last_pix  = pix_en && hcnt == ho_k + w_k - KW'(1) && vcnt == vo_k + h_k - KW'(1);
  assign addr      = line_base + AW'(px);

  logic tx_h;
  assign tx_h     = run && role_tx && line_end;
  assign tbus_out = {tx_h && last_line, tx_h};
  assign tbus_oe  = role_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_start <= '0; r_pitch <= '0;
      r_w <= '0; r_h <= '0; r_hb <= '0; r_vb <= '0; r_ho <= '0; r_vo <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        4'd0: r_start <= cfg_data;
        4'd1: r_pitch <= cfg_data;
        4'd2: r_w     <= cfg_data[CW-1:0];
        4'd3: r_h     <= cfg_data[CW-1:0];
        4'd4: r_hb    <= cfg_data[CW-1:0];
        4'd5: r_vb    <= cfg_data[CW-1:0];
        4'd6: r_ho    <= cfg_data[CW-1:0];
        4'd7: r_vo    <= cfg_data[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_tx <= 1'b0; rpt <= 1'b0; wait_v <= 1'b0; run <= 1'b0; done <= 1'b0;
      hcnt <= '0; vcnt <= '0; line_base <= '0; px <= '0;
    end else if (go) begin
      role_tx   <= cfg_data[1];
      rpt       <= cfg_data[2];
      run       <= cfg_data[1];
      wait_v    <= !cfg_data[1];
      done      <= 1'b0;
      hcnt      <= '0;
      vcnt      <= '0;
      line_base <= r_start;
      px        <= '0;
    end else begin
      if (ctl_wr) rpt <= cfg_data[2];
      if (wait_v) begin
        if (tbus_in[1]) begin
          wait_v    <= 1'b0;
          run       <= 1'b1;
          hcnt      <= '0;
          vcnt      <= '0;
          line_base <= r_start;
          px        <= '0;
        end
      end else if (run) begin
        if (last_pix) done <= 1'b1;
        if (pix_en) begin
          if (px == r_w - CW'(1)) begin
            px        <= '0;
            line_base <= line_base + r_pitch;
          end else begin
            px <= px + CW'(1);
          end
        end
        if (role_tx) begin
          if (line_end) begin
            hcnt <= '0;
            if (last_line) begin
              vcnt      <= '0;
              line_base <= r_start;
              px        <= '0;
              if (!(ctl_wr ? cfg_data[2] : rpt)) run <= 1'b0;
            end else begin
              vcnt <= vcnt + KW'(1);
            end
          end else begin
            hcnt <= hcnt + KW'(1);
          end
        end else begin
          if (tbus_in[1]) begin
            hcnt      <= '0;
            vcnt      <= '0;
            line_base <= r_start;
            px        <= '0;
          end else if (tbus_in[0]) begin
            hcnt <= '0;
            vcnt <= vcnt + KW'(1);
          end else begin
            hcnt <= hcnt + KW'(1);
          end
          if (last_pix) run <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/roi_timing_chk.sv
module roi_timing_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [3:0]    cfg_sel,
  input logic [AW-1:0] cfg_data,
  input logic [1:0]    tbus_out,
  input logic          tbus_oe,
  input logic          pix_en,
  input logic          done
);
  logic start_wr;
  assign start_wr = cfg_we && cfg_sel == 4'd8 && cfg_data[0];

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> (!pix_en && !done && !tbus_oe));

  assert_vsync_with_hsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tbus_out[1] |-> tbus_out[0]);

  assert_done_after_pixel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pix_en));

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_wr) |=> done);

  assert_start_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> !done);

  assert_receiver_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tbus_oe |-> tbus_out == 2'b00);
endmodule

bind roi_timing_gen roi_timing_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
  .tbus_out(tbus_out), .tbus_oe(tbus_oe), .pix_en(pix_en), .done(done)
);

// File: tb/roi_timing_gen_tb.sv
module roi_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we_a = 1'b0, we_b = 1'b0;
  logic [3:0] sel = '0;
  logic [AW-1:0] data = '0;
  logic [1:0] a_bus, b_bus, b_in;
  logic a_oe, b_oe, a_pe, b_pe, a_done, b_done;
  logic [AW-1:0] a_addr, b_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign b_in = a_oe ? a_bus : 2'b00;

  roi_timing_gen #(.CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_a), .cfg_sel(sel), .cfg_data(data),
    .tbus_in(2'b00), .tbus_out(a_bus), .tbus_oe(a_oe), .pix_en(a_pe), .addr(a_addr), .done(a_done));

  roi_timing_gen #(.CW(CW), .AW(AW)) rx_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_b), .cfg_sel(sel), .cfg_data(data),
    .tbus_in(b_in), .tbus_out(b_bus), .tbus_oe(b_oe), .pix_en(b_pe), .addr(b_addr), .done(b_done));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input bit to_rx, input int s, input int d);
    if (to_rx) we_b = 1'b1; else we_a = 1'b1;
    sel = 4'(s); data = AW'(d);
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic cfg(input bit to_rx, input int st, input int pt, input int w, input int h,
                     input int hb, input int vb, input int ho, input int vo);
    wr(to_rx, 0, st); wr(to_rx, 1, pt); wr(to_rx, 2, w); wr(to_rx, 3, h);
    wr(to_rx, 4, hb); wr(to_rx, 5, vb); wr(to_rx, 6, ho); wr(to_rx, 7, vo);
  endtask

  function automatic bit win(input int h, input int v, input int ho, input int vo, input int w, input int hh);
    return h >= ho && h < ho + w && v >= vo && v < vo + hh;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pix_en", a_pe, 0);
    chk("R1 done", a_done, 0);
    chk("R1 tbus_out", a_bus, 0);
    chk("R1 tbus_oe", a_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w = 1; w <= 4; w++)
      for (int h = 1; h <= 3; h++)
        for (int hb = 0; hb <= 2; hb++)
          for (int vb = 0; vb <= 1; vb++)
            for (int ho = 0; ho <= hb; ho++)
              for (int vo = 0; vo <= vb; vo++) begin
                int st, pt, L, F, lastt;
                st = (w * 131 + h * 17 + hb * 5 + ho * 3 + vo) & 16'hFFF;
                pt = w + hb + 3 + vo;
                L = w + hb; F = h + vb;
                lastt = (vo + h - 1) * L + ho + w - 1;
                cfg(0, st, pt, w, h, hb, vb, ho, vo);
                wr(0, 8, 3);
                for (int t = 0; t < L * F + 3; t++) begin
                  int hh, vv;
                  bit ep;
                  hh = t % L; vv = t / L;
                  if (t < L * F) begin
                    ep = win(hh, vv, ho, vo, w, h);
                    chk("R4 tx pix_en", a_pe, ep);
                    if (ep) begin
                      if (hh == ho && vv == vo) chk("R2 first address", a_addr, st);
                      chk("R5 tx addr", a_addr, (st + (vv - vo) * pt + hh - ho) & 16'hFFFF);
                    end
                    chk("R3 hsync", a_bus[0], hh == L - 1);
                    chk("R3 vsync", a_bus[1], hh == L - 1 && vv == F - 1);
                  end else begin
                    chk("R7 idle pix_en", a_pe, 0);
                    chk("R7 idle bus", a_bus, 0);
                  end
                  chk("R6 done", a_done, t > lastt);
                  chk("R10 tx oe", a_oe, 1);
                  @(negedge clk);
                end
              end

    cfg(0, 'h200, 'h10, 5, 3, 2, 2, 0, 0);
    cfg(1, 'h800, 'h40, 4, 2, 0, 0, 2, 1);
    wr(1, 8, 1);
    wr(0, 8, 7);
    for (int t = 0; t < 112; t++) begin
      int f, tt, hh, vv;
      f = t / 35; tt = t % 35; hh = tt % 7; vv = tt / 7;
      if (f < 3) begin
        chk("R7 repeat tx pix_en", a_pe, win(hh, vv, 0, 0, 5, 3));
        if (a_pe) chk("R5 repeat tx addr", a_addr, 'h200 + vv * 'h10 + hh);
        chk("R3 repeat hsync", a_bus[0], hh == 6);
      end else begin
        chk("R7 stop pix_en", a_pe, 0);
        chk("R7 stop bus", a_bus, 0);
      end
      chk("R6 tx done stays", a_done, t > 18);
      chk("R10 rx oe", b_oe, 0);
      chk("R10 rx bus", b_bus, 0);
      if (f == 0) begin
        chk("R8 rx waits pix_en", b_pe, 0);
        chk("R8 rx waits done", b_done, 0);
      end else if (f == 1) begin
        bit ep;
        ep = win(hh, vv, 2, 1, 4, 2);
        chk("R9 rx pix_en", b_pe, ep);
        if (ep) chk("R9 rx addr", b_addr, 'h800 + (vv - 1) * 'h40 + hh - 2);
        chk("R6 rx done", b_done, tt > 19);
      end else begin
        chk("R9 rx silent", b_pe, 0);
        chk("R9 rx done held", b_done, 1);
      end
      if (t == 80) begin
        we_a = 1'b1; sel = 4'd8; data = AW'(2);
      end else begin
        we_a = 1'b0;
      end
      @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule